// File: doc/BRIEF.md
# Triggered Sample Capture Controller

This block decides which ADC samples go into an on-chip sample buffer, and where each one goes. Software arms it with a one-cycle `arm` pulse. While it is armed, it watches a trigger condition. That condition is built from five target lines (four general I/O lines and a target reset line). A per-line mask and one logic operator combine the lines into a single signal, and that signal is then qualified as an edge or a level.

While it waits for the trigger, the controller can keep a history of samples in a circular region at the bottom of the buffer. When the trigger fires it reports where the oldest kept sample sits. It then waits a programmable number of cycles and records linearly until the buffer is full. Decimation can store only every Nth sample. The decimation phase is re-aligned to the trigger, so every capture samples at the same offsets from it.

Once the buffer is full, the controller stays finished until the next `arm` pulse. The buffer itself, the sample clock source and the host readback sit outside this block. All configuration inputs are expected to stay constant from the `arm` pulse until `done`.

Top module: `capture_ctrl`

## Requirements
- R1: After reset, `armed`, `triggered`, `done`, `wr_en` and `start_ptr` are all zero.
- R2: Each line whose `cfg_mask` bit is 0 is forced to the neutral value of the operator: 0 for OR, 1 for AND and NAND. The operator is encoded in `cfg_op` as 0 = OR, 1 = AND, 2 = NAND; the value 3 acts as OR.
- R3: `cfg_mode` selects the qualification: 0 = rising edge, 1 = falling edge, 2 = high level, 3 = low level. An edge compares the combined value with its value in the previous cycle. The previous value is 0 after reset.
- R4: A trigger condition has no effect unless the controller is armed. An `arm` pulse is taken only when the controller is idle or done.
- R5: With a delay of D cycles and decimation off, the first post-trigger write appears at the outputs D+2 clock cycles after the input change that makes the condition true.
- R6: When `cfg_pre_en` is set and P = `cfg_pre_len` (clamped to DEPTH-1) is non-zero, presamples are written while armed to addresses 0 through P-1. The address wraps from P-1 back to 0.
- R7: When the trigger fires, `start_ptr` takes the address of the oldest valid presample. That is the next presample write address if the region has filled, and 0 otherwise. It holds this value until the next arm.
- R8: After the trigger, writes go to consecutive addresses from P (0 without presampling) up to DEPTH-1. The write to DEPTH-1 sets `done`, and there are no further writes.
- R9: A decimation factor of 0 or 1 stores every sample. A factor N > 1 stores one sample in N. The first post-trigger store comes straight after the delay, and later stores follow every N cycles.
- R10: `wr_data` carries the `sample_in` value present in the cycle the write was decided.
- R11: `armed` is high only while waiting for the trigger. `triggered` is high from the trigger until the next arm. `done` is high only once the buffer is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_in | input | SAMPLE_W | ADC sample word |
| trig_lines | input | LINES | Target lines; bit 4 is the target reset line |
| cfg_mask | input | LINES | Per-line participation mask |
| cfg_op | input | 2 | Combining operator |
| cfg_mode | input | 2 | Edge or level qualification |
| cfg_delay | input | DELAY_W | Post-trigger delay in cycles |
| cfg_pre_en | input | 1 | Presampling enable |
| cfg_pre_len | input | ADDR_W | Presample region length |
| cfg_decim | input | DECIM_W | Decimation factor |
| arm | input | 1 | Arm request pulse |
| wr_en | output | 1 | Buffer write enable |
| wr_addr | output | ADDR_W | Buffer write address |
| wr_data | output | SAMPLE_W | Buffer write data |
| start_ptr | output | ADDR_W | Oldest valid presample address |
| armed | output | 1 | Waiting for trigger |
| triggered | output | 1 | Trigger seen in this capture |
| done | output | 1 | Buffer full |

## Verification
Some properties are checked on every cycle:
- every write address lies inside the buffer;
- a presample write stays below the region length;
- `armed` and `triggered` are never high together;
- no write follows the first cycle of `done`;
- `start_ptr` does not move once triggered.

Other behaviour can only be shown by the bench's scenarios, by comparing against a behavioural model and by measuring the outputs:
- the exact trigger cycle for each operator, mask and mode;
- the latency of the delay;
- the wrap of the presample region and the resulting `start_ptr`;
- the spacing between decimated writes;
- the number of writes up to full.

// File: rtl/capture_pkg.sv
`timescale 1ns/1ps
package capture_pkg;
    localparam logic [1:0] OP_OR   = 2'd0;
    localparam logic [1:0] OP_AND  = 2'd1;
    localparam logic [1:0] OP_NAND = 2'd2;

    localparam logic [1:0] MODE_RISE = 2'd0;
    localparam logic [1:0] MODE_FALL = 2'd1;
    localparam logic [1:0] MODE_HIGH = 2'd2;
    localparam logic [1:0] MODE_LOW  = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ARMED  = 3'd1,
        ST_DELAY  = 3'd2,
        ST_RECORD = 3'd3,
        ST_DONE   = 3'd4
    } cap_state_e;
endpackage

// File: rtl/trig_combine.sv
`timescale 1ns/1ps
module trig_combine
    import capture_pkg::*;
#(
    parameter int LINES = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] lines,
    input  logic [LINES-1:0] mask,
    input  logic [1:0]       op,
    input  logic [1:0]       mode,
    output logic             hit
);
    logic             neutral;
    logic [LINES-1:0] forced;
    logic             level;
    logic             prev_d, prev_q;

    // AND-type operators need 1 as the neutral value, OR needs 0
    assign neutral = (op == OP_AND) || (op == OP_NAND);

    for (genvar i = 0; i < LINES; i++) begin : g_force
        assign forced[i] = mask[i] ? lines[i] : neutral;
    end

    always_comb begin
        unique case (op)
            OP_AND:  level = &forced;
            OP_NAND: level = ~&forced;
            default: level = |forced;
        endcase
        unique case (mode)
            MODE_RISE: hit = level & ~prev_q;
            MODE_FALL: hit = ~level & prev_q;
            MODE_HIGH: hit = level;
            default:   hit = ~level;
        endcase
        prev_d = level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/decim_gate.sv
`timescale 1ns/1ps
module decim_gate #(
    parameter int DECIM_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic [DECIM_W-1:0] factor,
    output logic               tick
);
    logic [DECIM_W-1:0] span;
    logic [DECIM_W-1:0] cnt_d, cnt_q;

    // factors 0 and 1 both mean "keep every sample"
    assign span = (factor <= DECIM_W'(1)) ? DECIM_W'(1) : factor;
    assign tick = (cnt_q == '0);

    always_comb begin
        if (clear)                           cnt_d = '0;
        else if (cnt_q >= span - DECIM_W'(1)) cnt_d = '0;
        else                                 cnt_d = cnt_q + DECIM_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/capture_ctrl.sv
`timescale 1ns/1ps
module capture_ctrl
    import capture_pkg::*;
#(
    parameter int SAMPLE_W = 10,
    parameter int DEPTH    = 24573,
    parameter int LINES    = 5,
    parameter int DELAY_W  = 32,
    parameter int DECIM_W  = 16,
    parameter int ADDR_W   = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] sample_in,
    input  logic [LINES-1:0]    trig_lines,
    input  logic [LINES-1:0]    cfg_mask,
    input  logic [1:0]          cfg_op,
    input  logic [1:0]          cfg_mode,
    input  logic [DELAY_W-1:0]  cfg_delay,
    input  logic                cfg_pre_en,
    input  logic [ADDR_W-1:0]   cfg_pre_len,
    input  logic [DECIM_W-1:0]  cfg_decim,
    input  logic                arm,
    output logic                wr_en,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [SAMPLE_W-1:0] wr_data,
    output logic [ADDR_W-1:0]   start_ptr,
    output logic                armed,
    output logic                triggered,
    output logic                done
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

    typedef struct packed {
        cap_state_e          state;
        logic [ADDR_W-1:0]   pre_ptr;
        logic [ADDR_W-1:0]   pre_cnt;
        logic [ADDR_W-1:0]   rec_addr;
        logic [ADDR_W-1:0]   start_ptr;
        logic [DELAY_W-1:0]  dly_cnt;
        logic                wen;
        logic [ADDR_W-1:0]   waddr;
        logic [SAMPLE_W-1:0] wdata;
    } cap_regs_t;

    cap_regs_t         d, q;
    logic              hit;
    logic              tick;
    logic              arm_take;
    logic              hit_take;
    logic              decim_clear;
    logic [ADDR_W-1:0] pre_len_eff;

    trig_combine #(.LINES(LINES)) trig_i (
        .clk   (clk),
        .rst_n (rst_n),
        .lines (trig_lines),
        .mask  (cfg_mask),
        .op    (cfg_op),
        .mode  (cfg_mode),
        .hit   (hit)
    );

    // the decimation phase restarts on arm, on trigger and throughout the delay
    assign decim_clear = arm_take | hit_take | (q.state == ST_DELAY);

    decim_gate #(.DECIM_W(DECIM_W)) decim_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (decim_clear),
        .factor (cfg_decim),
        .tick   (tick)
    );

    // the presample region must leave at least one linear slot
    assign pre_len_eff = !cfg_pre_en ? '0 :
                         (cfg_pre_len > LAST_ADDR) ? LAST_ADDR : cfg_pre_len;

    always_comb begin
        d        = q;
        d.wen    = 1'b0;
        arm_take = 1'b0;
        hit_take = 1'b0;
        unique case (q.state)
            ST_IDLE, ST_DONE: begin
                if (arm) begin
                    arm_take    = 1'b1;
                    d.state     = ST_ARMED;
                    d.pre_ptr   = '0;
                    d.pre_cnt   = '0;
                    d.start_ptr = '0;
                end
            end
            ST_ARMED: begin
                if (hit) begin
                    hit_take    = 1'b1;
                    d.start_ptr = (pre_len_eff != '0 && q.pre_cnt == pre_len_eff)
                                  ? q.pre_ptr : '0;
                    d.rec_addr  = pre_len_eff;
                    d.dly_cnt   = '0;
                    d.state     = (cfg_delay == '0) ? ST_RECORD : ST_DELAY;
                end else if (tick && pre_len_eff != '0) begin
                    d.wen     = 1'b1;
                    d.waddr   = q.pre_ptr;
                    d.wdata   = sample_in;
                    d.pre_ptr = (q.pre_ptr == pre_len_eff - 1'b1) ? '0 : q.pre_ptr + 1'b1;
                    if (q.pre_cnt != pre_len_eff) d.pre_cnt = q.pre_cnt + 1'b1;
                end
            end
            ST_DELAY: begin
                d.dly_cnt = q.dly_cnt + 1'b1;
                if (q.dly_cnt == cfg_delay - 1'b1) d.state = ST_RECORD;
            end
            ST_RECORD: begin
                if (tick) begin
                    d.wen      = 1'b1;
                    d.waddr    = q.rec_addr;
                    d.wdata    = sample_in;
                    d.rec_addr = q.rec_addr + 1'b1;
                    if (q.rec_addr == LAST_ADDR) d.state = ST_DONE;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign wr_en     = q.wen;
    assign wr_addr   = q.waddr;
    assign wr_data   = q.wdata;
    assign start_ptr = q.start_ptr;
    assign armed     = (q.state == ST_ARMED);
    assign triggered = (q.state == ST_DELAY) || (q.state == ST_RECORD) || (q.state == ST_DONE);
    assign done      = (q.state == ST_DONE);
endmodule

// File: rtl/capture_ctrl_chk.sv
`timescale 1ns/1ps
module capture_ctrl_chk #(
    parameter int DEPTH  = 24573,
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [ADDR_W-1:0] start_ptr,
    input logic              armed,
    input logic              triggered,
    input logic              done,
    input logic              cfg_pre_en,
    input logic [ADDR_W-1:0] cfg_pre_len
);
    a_r8_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_addr) < DEPTH));

    a_r6_pre_below_len: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && wr_en) |-> (cfg_pre_en && wr_addr < cfg_pre_len));

    a_r11_armed_excl_trig: assert property (@(posedge clk) disable iff (!rst_n)
        !(armed && triggered));

    a_r8_no_write_after_full: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(done)) |-> !wr_en);

    a_r7_start_held: assert property (@(posedge clk) disable iff (!rst_n)
        (triggered && $past(triggered)) |-> $stable(start_ptr));

    a_r11_done_implies_trig: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> triggered);
endmodule

bind capture_ctrl capture_ctrl_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .start_ptr   (start_ptr),
    .armed       (armed),
    .triggered   (triggered),
    .done        (done),
    .cfg_pre_en  (cfg_pre_en),
    .cfg_pre_len (cfg_pre_len)
);

// File: tb/capture_ctrl_tb_top.sv
`timescale 1ns/1ps
module capture_ctrl_tb_top;
    localparam int DEPTH = 100;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [9:0]    sample_in = '0;
    logic [4:0]    trig_lines = '0;
    logic [4:0]    cfg_mask = '0;
    logic [1:0]    cfg_op = '0;
    logic [1:0]    cfg_mode = '0;
    logic [31:0]   cfg_delay = '0;
    logic          cfg_pre_en = 1'b0;
    logic [AW-1:0] cfg_pre_len = '0;
    logic [15:0]   cfg_decim = '0;
    logic          arm = 1'b0;
    logic          wr_en, armed, triggered, done;
    logic [AW-1:0] wr_addr, start_ptr;
    logic [9:0]    wr_data;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit fin    = 0;

    always #2.5 clk = ~clk;

    capture_ctrl #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .sample_in(sample_in), .trig_lines(trig_lines),
        .cfg_mask(cfg_mask), .cfg_op(cfg_op), .cfg_mode(cfg_mode), .cfg_delay(cfg_delay),
        .cfg_pre_en(cfg_pre_en), .cfg_pre_len(cfg_pre_len), .cfg_decim(cfg_decim),
        .arm(arm), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .start_ptr(start_ptr), .armed(armed), .triggered(triggered), .done(done)
    );

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int  m_st;      // 0 idle, 1 armed, 2 delay, 3 record, 4 done
    bit  m_prev;
    int  m_dc, m_pre_ptr, m_pre_cnt, m_rec, m_start, m_waddr, m_wdata;
    longint m_dcnt;
    bit  m_wen;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_prev = 0; m_dc = 0; m_pre_ptr = 0; m_pre_cnt = 0;
            m_rec = 0; m_start = 0; m_wen = 0; m_waddr = 0; m_wdata = 0; m_dcnt = 0;
        end else begin
            bit c, hit, tick, clr;
            int n, effp;
            bit [4:0] f;
            for (int i = 0; i < 5; i++)
                f[i] = cfg_mask[i] ? trig_lines[i] : (cfg_op == 2'd1 || cfg_op == 2'd2);
            c = (cfg_op == 2'd1) ? (&f) : (cfg_op == 2'd2) ? !(&f) : (|f);
            case (cfg_mode)
                2'd0: hit = c && !m_prev;
                2'd1: hit = !c && m_prev;
                2'd2: hit = c;
                default: hit = !c;
            endcase
            n    = (cfg_decim <= 1) ? 1 : int'(cfg_decim);
            tick = (m_dc == 0);
            effp = !cfg_pre_en ? 0 : (int'(cfg_pre_len) > DEPTH - 1 ? DEPTH - 1 : int'(cfg_pre_len));
            clr  = 0;
            m_wen = 0;
            case (m_st)
                0, 4: if (arm) begin
                    m_st = 1; m_pre_ptr = 0; m_pre_cnt = 0; m_start = 0; clr = 1;
                end
                1: if (hit) begin
                    m_start = (effp != 0 && m_pre_cnt == effp) ? m_pre_ptr : 0;
                    m_rec = effp; m_dcnt = 0; clr = 1;
                    m_st = (cfg_delay == 0) ? 3 : 2;
                end else if (tick && effp != 0) begin
                    m_wen = 1; m_waddr = m_pre_ptr; m_wdata = int'(sample_in);
                    m_pre_ptr = (m_pre_ptr == effp - 1) ? 0 : m_pre_ptr + 1;
                    if (m_pre_cnt < effp) m_pre_cnt++;
                end
                2: begin
                    clr = 1;
                    if (m_dcnt == longint'(cfg_delay) - 1) m_st = 3;
                    m_dcnt++;
                end
                3: if (tick) begin
                    m_wen = 1; m_waddr = m_rec; m_wdata = int'(sample_in);
                    if (m_rec == DEPTH - 1) m_st = 4;
                    m_rec++;
                end
                default: m_st = 0;
            endcase
            m_dc = clr ? 0 : ((m_dc >= n - 1) ? 0 : m_dc + 1);
            m_prev = c;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !fin) begin
            check("R8", "wr_en", wr_en, m_wen);
            if (m_wen) begin
                check("R8", "wr_addr", wr_addr, m_waddr);
                check("R10", "wr_data", wr_data, m_wdata);
            end
            check("R11", "flags", {armed, triggered, done},
                  {m_st == 1, (m_st == 2 || m_st == 3 || m_st == 4), m_st == 4});
            check("R7", "start_ptr", start_ptr, m_start);
        end
    end

    always @(negedge clk) sample_in <= sample_in + 10'd7;

    task automatic summary();
        fin = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            fails++;
            $display("FAIL R8 watchdog actual=%0d expected<150000", cyc);
            summary();
        end
    end

    task automatic pulse_arm();
        @(negedge clk) arm = 1'b1;
        @(negedge clk) arm = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // call right after driving the trigger-making change at a negedge
    task automatic measure(output int lat, output int nwr, output int gmin, output int gmax);
        int t = 0;
        int last = -1;
        lat = -1; nwr = 0; gmin = 1 << 30; gmax = 0;
        forever begin
            @(negedge clk);
            t++;
            if (wr_en && triggered) begin
                if (lat < 0) lat = t;
                if (last >= 0) begin
                    if (t - last < gmin) gmin = t - last;
                    if (t - last > gmax) gmax = t - last;
                end
                last = t;
                nwr++;
            end
            if (done) break;
            if (t > 5000) begin
                fails++;
                $display("FAIL R8 capture_end actual=timeout expected=done");
                break;
            end
        end
    endtask

    initial begin
        int lat, nwr, gmin, gmax, cnt;
        idle(3);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset state
        check("R1", "flags_after_reset", {armed, triggered, done, wr_en}, 0);
        check("R1", "start_ptr_after_reset", start_ptr, 0);

        // R4: trigger activity while idle has no effect
        cfg_mask = 5'b00001; cfg_op = 2'd0; cfg_mode = 2'd0; cfg_decim = 16'd1;
        cnt = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk) trig_lines[0] = ~trig_lines[0];
            if (wr_en || triggered) cnt++;
        end
        check("R4", "idle_activity", cnt, 0);
        trig_lines = '0;

        // S3: OR on line0, rising edge, no delay, no presample
        pulse_arm();
        idle(3);
        check("R11", "armed_waiting", armed, 1);
        trig_lines[0] = 1'b1;
        measure(lat, nwr, gmin, gmax);
        check("R5", "latency_delay0", lat, 2);
        check("R8", "writes_full", nwr, DEPTH);
        check("R3", "rise_gap", gmax, 1);

        // R4: activity while done has no effect
        cnt = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk) trig_lines = ~trig_lines;
            if (wr_en) cnt++;
        end
        check("R4", "done_writes", cnt, 0);
        check("R4", "done_held", done, 1);
        trig_lines = '0;

        // S4: AND of lines 0,1, high level, delay 5, presample 10 (wraps)
        cfg_mask = 5'b00011; cfg_op = 2'd1; cfg_mode = 2'd2; cfg_delay = 32'd5;
        cfg_pre_en = 1'b1; cfg_pre_len = AW'(10);
        pulse_arm();
        idle(25);
        @(negedge clk) trig_lines[0] = 1'b1;
        idle(4);
        check("R2", "and_partial_no_trigger", armed, 1);
        trig_lines[1] = 1'b1;
        measure(lat, nwr, gmin, gmax);
        check("R5", "latency_delay5", lat, 7);
        check("R8", "writes_after_pre", nwr, DEPTH - 10);
        check("R7", "start_wrapped", start_ptr, m_start);
        check("R6", "start_inside_region", int'(start_ptr) < 10, 1);
        trig_lines = '0;

        // S5: NAND on line2, falling edge, delay 2, decim 3, presample 7 not filled
        cfg_mask = 5'b00100; cfg_op = 2'd2; cfg_mode = 2'd1; cfg_delay = 32'd2;
        cfg_decim = 16'd3; cfg_pre_len = AW'(7);
        pulse_arm();
        idle(4);
        trig_lines[2] = 1'b1;
        measure(lat, nwr, gmin, gmax);
        check("R7", "start_unfilled", start_ptr, 0);
        check("R5", "latency_decim_restart", lat, 4);
        check("R9", "decim_gap_min", gmin, 3);
        check("R9", "decim_gap_max", gmax, 3);
        check("R8", "writes_decim", nwr, DEPTH - 7);

        // S6: OR on line4 only, low level, decim 0, arm while armed ignored
        trig_lines = 5'b10000;
        cfg_mask = 5'b10000; cfg_op = 2'd3; cfg_mode = 2'd3; cfg_delay = '0;
        cfg_pre_en = 1'b0; cfg_decim = '0;
        pulse_arm();
        for (int i = 0; i < 6; i++) @(negedge clk) trig_lines[3:0] = ~trig_lines[3:0];
        pulse_arm();
        check("R2", "masked_lines_ignored", armed, 1);
        trig_lines = '0;
        measure(lat, nwr, gmin, gmax);
        check("R3", "low_level_latency", lat, 2);
        check("R9", "decim0_every_sample", nwr, DEPTH);
        check("R9", "decim0_gap", gmax, 1);

        idle(3);
        summary();
    end
endmodule